// File: doc/BRIEF.md
# Serial GPIO Command and Status Engine

This block holds the command and status register of a serial GPIO enclosure-management controller. When the host writes a command code, the block starts one of four operations: controller reset, parameter read, data read or data write. It passes the operation to a downstream bit shifter with a one-cycle start pulse. While the shifter works, the block reports the command as active. When the shifter answers, the block reports OK or error. If the shifter never answers, a cycle-count timeout ends the command with an error.

Every completion flips a sequence bit, so a host that polls the register can tell a new result from an old one. A two-bit controller-state field shows whether the controller is in reset, operational or in error. Only a reset command that completes cleanly brings the controller back to operational. The timeout is derived from the clock frequency and a limit in milliseconds, and both are parameters.

Top module: `sgpio_cmd_engine`

## Requirements
- R1: After reset, the whole 32-bit register reads 0: status OK, sequence bit 0, controller state reset.
- R2: Readback layout. Bits 4:3 hold the command status: 0 = OK, 1 = active, 2 = error. Bit 2 is the sequence bit. Bits 1:0 hold the controller state: 0 = reset, 1 = operational, 2 = error. All other bits read 0.
- R3: A write of command code 0..3 while the status is not active is accepted. Code 0 is reset, 1 is read parameters, 2 is read data and 3 is write data. Acceptance raises `sh_start` for exactly one cycle with `sh_op` equal to the code, and the status reads active from the next cycle.
- R4: While the status is active, `sh_done` with `sh_err` = 0 makes the status OK at the next edge. With `sh_err` = 1, the status and the controller state both become error at that edge. In both cases the sequence bit flips at that same edge.
- R5: A command write made while the status is active is ignored: no start pulse, and the status stays active.
- R6: If a command stays active for LIMIT = (CLK_HZ/1000)*TIMEOUT_MS cycles without `sh_done`, it ends at that edge. The status and the controller state become error and the sequence bit flips.
- R7: Accepting a reset command (code 0) sets the controller state to reset. If it completes without error, the state becomes operational, and this also clears an earlier error state. Other commands that complete OK leave the controller state unchanged.
- R8: A write of codes 4..7 while not active sets the status to error and flips the sequence bit at the next edge. It gives no start pulse and leaves the controller state unchanged.
- R9: `sh_done` while the status is not active has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the command field |
| wr_cmd | input | 3 | Command field of the host write (register bits 7:5) |
| rd_data | output | 32 | Register readback |
| sh_start | output | 1 | One-cycle start to the shifter |
| sh_op | output | 2 | Operation code held for the shifter |
| sh_done | input | 1 | Shifter completion |
| sh_err | input | 1 | Shifter completion carries an error |

## Verification
A stuck or wrong status field shows up on `rd_data` at the first negative edge after the edge that should have changed it. A sequence bit that fails to flip, or flips twice, is caught at the completion edge itself. A timeout counter that is off by one makes the status drop out of active one cycle early or late, which the per-cycle comparison reports at that exact cycle. A bad latch of the operation code shows up on `sh_op` during the start pulse. If the operation register is corrupted, the controller state is wrong after a reset command completes.

// File: rtl/sgpio_cmd_engine.sv
module sgpio_cmd_engine #(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned TIMEOUT_MS = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_cmd,
  output logic [31:0] rd_data,
  output logic        sh_start,
  output logic [1:0]  sh_op,
  input  logic        sh_done,
  input  logic        sh_err
);
  localparam int unsigned LIMIT = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  localparam logic [1:0] CS_OK   = 2'd0;
  localparam logic [1:0] CS_BUSY = 2'd1;
  localparam logic [1:0] CS_ERR  = 2'd2;
  localparam logic [1:0] CT_RST  = 2'd0;
  localparam logic [1:0] CT_RUN  = 2'd1;
  localparam logic [1:0] CT_ERR  = 2'd2;

  logic [1:0]    cstat;
  logic [1:0]    ctl;
  logic          seq;
  logic [CW-1:0] age;

  wire busy   = (cstat == CS_BUSY);
  wire accept = wr_en && !busy;
  wire legal  = !wr_cmd[2];
  wire expire = busy && !sh_done && (age == CW'(LIMIT - 1));

  assign rd_data = {27'd0, cstat, seq, ctl};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cstat    <= CS_OK;
      ctl      <= CT_RST;
      seq      <= 1'b0;
      age      <= '0;
      sh_start <= 1'b0;
      sh_op    <= 2'd0;
    end else begin
      sh_start <= accept && legal;
      if (accept) begin
        age <= '0;
        if (legal) begin
          cstat <= CS_BUSY;
          sh_op <= wr_cmd[1:0];
          if (wr_cmd[1:0] == 2'd0) ctl <= CT_RST;
        end else begin
          cstat <= CS_ERR;
          seq   <= ~seq;
        end
      end else if (busy) begin
        if (sh_done) begin
          seq <= ~seq;
          if (sh_err) begin
            cstat <= CS_ERR;
            ctl   <= CT_ERR;
          end else begin
            cstat <= CS_OK;
            if (sh_op == 2'd0) ctl <= CT_RUN;
          end
        end else if (expire) begin
          seq   <= ~seq;
          cstat <= CS_ERR;
          ctl   <= CT_ERR;
        end else begin
          age <= age + 1'b1;
        end
      end
    end
  end
endmodule

module sgpio_cmd_engine_chk #(
  parameter int unsigned LIMIT = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_cmd,
  input logic [4:0] stat,
  input logic       sh_start,
  input logic       sh_done,
  input logic       sh_err
);
  wire [1:0] cs = stat[4:3];
  wire [1:0] st = stat[1:0];
  wire       sq = stat[2];
  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else if (cs == 2'd1) run <= run + 1;
    else run <= 0;
  end

  a_r2_no_reserved_codes: assert property (@(posedge clk) disable iff (!rst_n)
    cs != 2'd3 && st != 2'd3);
  a_r3_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |=> !sh_start);
  a_r3_start_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> cs == 2'd1);
  a_r4_seq_flips_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 2'd1) |=> ((cs != 2'd1) == (sq != $past(sq))));
  a_r4_error_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 2'd1 && sh_done && sh_err) |=> (cs == 2'd2 && st == 2'd2));
  a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 2'd1 && wr_en && !sh_done) |=> !sh_start);
  a_r6_bounded_busy: assert property (@(posedge clk) disable iff (!rst_n)
    run <= LIMIT);
  a_r8_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != 2'd1 && wr_en && wr_cmd[2]) |=> (!sh_start && cs == 2'd2 && $stable(st)));
  a_r9_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != 2'd1 && !wr_en && sh_done) |=> ($stable(cs) && $stable(sq) && $stable(st)));
endmodule

bind sgpio_cmd_engine sgpio_cmd_engine_chk #(.LIMIT((CLK_HZ / 1000) * TIMEOUT_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .stat(rd_data[4:0]),
  .sh_start(sh_start), .sh_done(sh_done), .sh_err(sh_err)
);

// File: tb/test_sgpio_cmd_engine.sv
module test_sgpio_cmd_engine;
  localparam int CLK_HZ = 20000;
  localparam int TMS    = 1;
  localparam int LIM    = (CLK_HZ / 1000) * TMS;

  logic clk = 0, rst_n = 0, wr_en = 0, sh_done = 0, sh_err = 0;
  logic [2:0] wr_cmd = 0;
  logic [31:0] rd_data;
  logic sh_start;
  logic [1:0] sh_op;

  always #2 clk = ~clk;

  sgpio_cmd_engine #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMS)) i_sgpio_cmd_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .rd_data(rd_data),
    .sh_start(sh_start), .sh_op(sh_op), .sh_done(sh_done), .sh_err(sh_err));

  int errors = 0, checks = 0;
  bit finished = 0;
  string cur = "R1";

  int m_cs, m_seq, m_st, m_op, m_cnt;
  bit m_start;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = 0; m_seq = 0; m_st = 0; m_op = 0; m_cnt = 0; m_start = 0;
    end else begin
      m_start = 0;
      if (m_cs == 1) begin
        if (sh_done) begin
          m_seq = 1 - m_seq;
          if (sh_err) begin m_cs = 2; m_st = 2; end
          else begin m_cs = 0; if (m_op == 0) m_st = 1; end
        end else if (m_cnt == LIM - 1) begin
          m_seq = 1 - m_seq; m_cs = 2; m_st = 2;
        end else m_cnt++;
      end else if (wr_en) begin
        if (wr_cmd > 3) begin m_cs = 2; m_seq = 1 - m_seq; end
        else begin
          m_cs = 1; m_start = 1; m_op = wr_cmd; m_cnt = 0;
          if (wr_cmd == 0) m_st = 0;
        end
      end
    end
  end

  task automatic compare();
    logic [31:0] exp;
    exp = 32'(m_cs) << 3 | 32'(m_seq) << 2 | 32'(m_st);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd_data actual=%h expected=%h", cur, rd_data, exp);
    end
    checks++;
    if (sh_start !== m_start || (m_start && sh_op !== 2'(m_op))) begin
      errors++;
      $display("FAIL %s start/op actual=%b/%0d expected=%b/%0d", cur, sh_start, sh_op, m_start, m_op);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) compare();
  endtask

  task automatic expect_reg(string req, int cs, int st);
    checks++;
    if (rd_data[4:3] !== 2'(cs) || rd_data[1:0] !== 2'(st)) begin
      errors++;
      $display("FAIL %s status/state actual=%0d/%0d expected=%0d/%0d", req, rd_data[4:3], rd_data[1:0], cs, st);
    end
  endtask

  task automatic issue(int c);
    wr_en = 1; wr_cmd = 3'(c); tick(); wr_en = 0;
  endtask

  task automatic finish_op(bit e);
    sh_done = 1; sh_err = e; tick(); sh_done = 0; sh_err = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    logic s0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick();
    checks++;
    if (rd_data !== 32'h0) begin
      errors++; $display("FAIL R1 reset actual=%h expected=0", rd_data);
    end
    cur = "R7"; issue(0); expect_reg("R7", 1, 0);
    idle(2); finish_op(0); expect_reg("R7", 0, 1);
    cur = "R3"; issue(1);
    checks++;
    if (sh_start !== 1'b1 || sh_op !== 2'd1) begin
      errors++; $display("FAIL R3 start actual=%b op=%0d expected=1 op=1", sh_start, sh_op);
    end
    tick(); finish_op(0);
    cur = "R2"; issue(2); finish_op(0); expect_reg("R2", 0, 1);
    cur = "R4"; issue(3); idle(1); finish_op(0);
    cur = "R5"; issue(2); wr_en = 1; wr_cmd = 3; tick(); wr_en = 0;
    expect_reg("R5", 1, 1); finish_op(0);
    cur = "R4"; issue(3); finish_op(1); expect_reg("R4", 2, 2);
    cur = "R9"; s0 = rd_data[2]; sh_done = 1; tick(); sh_done = 0; tick();
    expect_reg("R9", 2, 2);
    checks++;
    if (rd_data[2] !== s0) begin
      errors++; $display("FAIL R9 seq actual=%b expected=%b", rd_data[2], s0);
    end
    cur = "R7"; issue(0); expect_reg("R7", 1, 0); finish_op(0); expect_reg("R7", 0, 1);
    cur = "R8"; s0 = rd_data[2]; issue(5); expect_reg("R8", 2, 1);
    checks++;
    if (rd_data[2] === s0 || sh_start !== 1'b0) begin
      errors++; $display("FAIL R8 seq/start actual=%b/%b expected=%b/0", rd_data[2], sh_start, ~s0);
    end
    issue(7); issue(4); expect_reg("R8", 2, 1);
    cur = "R6"; issue(1); idle(LIM - 1); expect_reg("R6", 1, 1);
    tick(); expect_reg("R6", 2, 2); idle(3);
    cur = "R7"; issue(0); finish_op(1); expect_reg("R7", 2, 2);
    issue(0); tick(); finish_op(0); expect_reg("R7", 0, 1);
    cur = "R3"; issue(1); finish_op(0); issue(0); finish_op(0); idle(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule